// File: doc/BRIEF.md
# Interrupt-Driven Control Response Frame Reader

This block fetches one response frame from a target device on an I2C bus. It stays idle until the target raises its interrupt line. It then opens a read to the target's address and pulls in a three-byte header. The third header byte gives the payload size, and the block reads exactly that many payload bytes after it. The reader never handles SCL or SDA timing itself. It drives a byte-level bus engine through single-cycle commands (`cmd_valid`, `cmd_op`, `cmd_byte`, `cmd_nack`) and waits for the engine's single-cycle `eng_done` after each one.

Each received byte appears on `out_data` with a one-cycle `out_valid`. The first byte is flagged `out_sof` and the last is flagged `out_eof`. After the final byte the reader sends a STOP. It then watches the interrupt line: a target that has handed over everything drops the line, and one that keeps it high still holds data. Three faults are reported:
- `err_mismatch`: the header does not describe the expected response.
- `err_underread`: data was left behind in the target.
- `err_timeout`: the engine stopped answering.

Top module: `nci_rsp_reader`

## Requirements
- R1: A read begins only when `irq_in` is 1 while the reader is idle. It begins with a command of op 0 (START plus address byte) whose `cmd_byte` is the 7-bit target address followed by R/W = 1. That byte is 0x51 with the default address 0x28.
- R2: After the address phase the reader issues op 1 (read one byte) exactly N+3 times per frame. N is the value of the third received byte.
- R3: Every received byte appears once on `out_data` with a one-cycle `out_valid`, in the order it arrived. `out_sof` is set with the first byte only and `out_eof` with the last byte only.
- R4: Each received byte is followed by an op 2 (acknowledge bit) command. `cmd_nack` is 0 for every byte except the last of the frame, where it is 1. When N is 0, the third byte is the one that is NACKed.
- R5: The NACK of the last byte is followed by exactly one op 3 (STOP) command. After that the reader returns to idle as soon as `irq_in` reads 0.
- R6: If `irq_in` is still 1 CLR_WAIT cycles after the STOP completes, `err_underread` is set. It stays set until reset, and the reader goes idle, so a new read can start while `irq_in` remains high.
- R7: `err_mismatch` pulses together with `out_eof` when the first byte is not 0x40 or the second byte differs from `exp_oid`. It stays 0 otherwise.
- R8: If `eng_done` has not arrived `tmo_limit` cycles after a command is issued, `err_timeout` is set. It stays set until reset. If the pending command was not a STOP, a STOP (op 3) is issued in the same cycle, and the reader then returns to idle.
- R9: After reset, `cmd_valid`, `out_valid`, `out_sof`, `out_eof`, `err_mismatch`, `err_underread` and `err_timeout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 1 | Target interrupt line, already synchronous to `clk` |
| exp_oid | input | 8 | Opcode expected in the second header byte |
| tmo_limit | input | TMO_W | Cycles allowed for the engine to complete a command |
| cmd_valid | output | 1 | One-cycle command strobe to the byte engine |
| cmd_op | output | 2 | Command: 0 start+address, 1 read byte, 2 acknowledge bit, 3 stop |
| cmd_byte | output | 8 | Address byte for op 0, zero otherwise |
| cmd_nack | output | 1 | Acknowledge-bit value for op 2 (1 = NACK) |
| eng_done | input | 1 | One-cycle completion strobe from the engine |
| eng_rx_byte | input | 8 | Byte received by the engine, valid with `eng_done` after op 1 |
| out_valid | output | 1 | Received byte strobe |
| out_data | output | 8 | Received byte |
| out_sof | output | 1 | Marks the first byte of a frame |
| out_eof | output | 1 | Marks the last byte of a frame |
| err_mismatch | output | 1 | Header mismatch pulse, coincident with `out_eof` |
| err_underread | output | 1 | Sticky: interrupt stayed high after a frame |
| err_timeout | output | 1 | Sticky: engine completion overdue |

## Verification
The bench sweeps payload lengths from 0 to 9, plus 31 and 255, across several engine latencies and header values. These are the cases where an off-by-one in length tracking appears.

An empty payload is the sharpest case. A design that decides the acknowledge before seeing the length byte would ACK the third byte, then read past the end of the frame. That would show up as an extra read command and a missing `out_eof`.

Mismatched message types and opcodes check that the error fires only on the last byte. A stuck-high interrupt checks the underread window length and that the flag is sticky. It also checks that a fresh read follows. A silent engine, tried at several `tmo_limit` values, checks the exact timeout cycle and the STOP that the abort issues.

// File: rtl/nci_rd_pkg.sv
package nci_rd_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = BYTE_W + 1;
    localparam logic [BYTE_W-1:0] MT_RESPONSE = 8'h40;

    typedef enum logic [1:0] {
        OP_START_ADDR = 2'd0,
        OP_READ       = 2'd1,
        OP_ACKBIT     = 2'd2,
        OP_STOP       = 2'd3
    } eng_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_W,
        ST_RD_W,
        ST_ACK_W,
        ST_STOP_W,
        ST_CLR,
        ST_ABORT_W
    } rd_state_e;

    typedef struct packed {
        rd_state_e         st;
        logic              cmd_valid;
        eng_op_e           op;
        logic [BYTE_W-1:0] cmd_byte;
        logic              nack;
        logic              last;
        logic              out_valid;
        logic [BYTE_W-1:0] out_data;
        logic              sof;
        logic              eof;
        logic              mism;
        logic              err_under;
        logic              err_tmo;
    } seq_regs_t;

endpackage

// File: rtl/nci_rd_cycle_timer.sv
module nci_rd_cycle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt_d, cnt_q;

    assign hit = (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en && !hit) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/nci_rd_len_track.sv
module nci_rd_len_track
    import nci_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              stb,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [IDX_W-1:0]  idx,
    output logic              first,
    output logic              last
);

    localparam logic [IDX_W-1:0] LEN_POS = IDX_W'(2);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] len;
    } trk_t;

    trk_t trk_d, trk_q;

    assign idx   = trk_q.idx;
    assign first = (trk_q.idx == '0);

    // The length byte may itself be the last one (empty payload), so the
    // decision uses the byte being delivered right now.
    always_comb begin
        if (trk_q.idx == LEN_POS) begin
            last = (rx_byte == '0);
        end else if (trk_q.idx > LEN_POS) begin
            last = (trk_q.idx == ({1'b0, trk_q.len} + LEN_POS));
        end else begin
            last = 1'b0;
        end
    end

    always_comb begin
        trk_d = trk_q;
        if (clr) begin
            trk_d.idx = '0;
            trk_d.len = '0;
        end else if (stb) begin
            trk_d.idx = trk_q.idx + IDX_W'(1);
            if (trk_q.idx == LEN_POS) begin
                trk_d.len = rx_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

endmodule

// File: rtl/nci_rd_hdr_check.sv
module nci_rd_hdr_check
    import nci_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              stb,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] exp_oid,
    output logic              bad
);

    logic bad_d, bad_q;
    logic cur_bad;

    always_comb begin
        cur_bad = 1'b0;
        if (stb && idx == IDX_W'(0) && rx_byte != MT_RESPONSE) begin
            cur_bad = 1'b1;
        end
        if (stb && idx == IDX_W'(1) && rx_byte != exp_oid) begin
            cur_bad = 1'b1;
        end
    end

    assign bad = bad_q | cur_bad;

    always_comb begin
        bad_d = bad_q;
        if (clr) begin
            bad_d = 1'b0;
        end else if (cur_bad) begin
            bad_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_q <= 1'b0;
        end else begin
            bad_q <= bad_d;
        end
    end

endmodule

// File: rtl/nci_rd_seq.sv
module nci_rd_seq
    import nci_rd_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_in,
    input  logic              eng_done,
    input  logic [BYTE_W-1:0] eng_rx_byte,
    input  logic              tmo_hit,
    input  logic              win_hit,
    input  logic              byte_first,
    input  logic              byte_last,
    input  logic              hdr_bad,
    output logic              tmr_clr,
    output logic              tmr_en,
    output logic              win_clr,
    output logic              win_en,
    output logic              frm_clr,
    output logic              byte_stb,
    output seq_regs_t         regs
);

    seq_regs_t cur_q, nxt_d;
    logic      in_wait;

    function automatic seq_regs_t issue(input seq_regs_t r, input eng_op_e op,
                                        input logic nack);
        seq_regs_t o;
        o           = r;
        o.cmd_valid = 1'b1;
        o.op        = op;
        o.nack      = nack;
        o.cmd_byte  = (op == OP_START_ADDR) ? {TGT_ADDR, 1'b1} : '0;
        return o;
    endfunction

    assign regs = cur_q;

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.cmd_valid = 1'b0;
        nxt_d.out_valid = 1'b0;
        nxt_d.sof       = 1'b0;
        nxt_d.eof       = 1'b0;
        nxt_d.mism      = 1'b0;

        in_wait  = (cur_q.st == ST_ADDR_W) || (cur_q.st == ST_RD_W) ||
                   (cur_q.st == ST_ACK_W)  || (cur_q.st == ST_STOP_W) ||
                   (cur_q.st == ST_ABORT_W);
        tmr_en   = in_wait;
        tmr_clr  = !in_wait || eng_done || tmo_hit;
        win_en   = (cur_q.st == ST_CLR);
        win_clr  = !win_en;
        frm_clr  = 1'b0;
        byte_stb = 1'b0;

        case (cur_q.st)
            ST_IDLE: begin
                if (irq_in) begin
                    frm_clr  = 1'b1;
                    nxt_d    = issue(nxt_d, OP_START_ADDR, 1'b0);
                    nxt_d.st = ST_ADDR_W;
                end
            end
            ST_ADDR_W: begin
                if (eng_done) begin
                    nxt_d    = issue(nxt_d, OP_READ, 1'b0);
                    nxt_d.st = ST_RD_W;
                end else if (tmo_hit) begin
                    nxt_d         = issue(nxt_d, OP_STOP, 1'b0);
                    nxt_d.err_tmo = 1'b1;
                    nxt_d.st      = ST_ABORT_W;
                end
            end
            ST_RD_W: begin
                if (eng_done) begin
                    byte_stb        = 1'b1;
                    nxt_d.out_valid = 1'b1;
                    nxt_d.out_data  = eng_rx_byte;
                    nxt_d.sof       = byte_first;
                    nxt_d.eof       = byte_last;
                    nxt_d.mism      = byte_last && hdr_bad;
                    nxt_d.last      = byte_last;
                    nxt_d           = issue(nxt_d, OP_ACKBIT, byte_last);
                    nxt_d.st        = ST_ACK_W;
                end else if (tmo_hit) begin
                    nxt_d         = issue(nxt_d, OP_STOP, 1'b0);
                    nxt_d.err_tmo = 1'b1;
                    nxt_d.st      = ST_ABORT_W;
                end
            end
            ST_ACK_W: begin
                if (eng_done) begin
                    if (cur_q.last) begin
                        nxt_d    = issue(nxt_d, OP_STOP, 1'b0);
                        nxt_d.st = ST_STOP_W;
                    end else begin
                        nxt_d    = issue(nxt_d, OP_READ, 1'b0);
                        nxt_d.st = ST_RD_W;
                    end
                end else if (tmo_hit) begin
                    nxt_d         = issue(nxt_d, OP_STOP, 1'b0);
                    nxt_d.err_tmo = 1'b1;
                    nxt_d.st      = ST_ABORT_W;
                end
            end
            ST_STOP_W: begin
                if (eng_done) begin
                    nxt_d.st = ST_CLR;
                end else if (tmo_hit) begin
                    nxt_d.err_tmo = 1'b1;
                    nxt_d.st      = ST_IDLE;
                end
            end
            ST_CLR: begin
                if (!irq_in) begin
                    nxt_d.st = ST_IDLE;
                end else if (win_hit) begin
                    nxt_d.err_under = 1'b1;
                    nxt_d.st        = ST_IDLE;
                end
            end
            ST_ABORT_W: begin
                if (eng_done || tmo_hit) begin
                    nxt_d.st = ST_IDLE;
                end
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
            cur_q.op <= OP_START_ADDR;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/nci_rsp_reader.sv
module nci_rsp_reader
    import nci_rd_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h28,
    parameter int         TMO_W    = 16,
    parameter int         CLR_WAIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_in,
    input  logic [7:0]       exp_oid,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [7:0]       cmd_byte,
    output logic             cmd_nack,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx_byte,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             err_mismatch,
    output logic             err_underread,
    output logic             err_timeout
);

    localparam int WIN_W = $clog2(CLR_WAIT + 1);

    logic             tmr_clr, tmr_en, tmo_hit;
    logic             win_clr, win_en, win_hit;
    logic             frm_clr, byte_stb;
    logic             byte_first, byte_last, hdr_bad;
    logic [IDX_W-1:0] byte_idx;
    seq_regs_t        regs;

    nci_rd_cycle_timer #(.W(TMO_W)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .en    (tmr_en),
        .limit (tmo_limit),
        .hit   (tmo_hit)
    );

    nci_rd_cycle_timer #(.W(WIN_W)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .en    (win_en),
        .limit (WIN_W'(CLR_WAIT)),
        .hit   (win_hit)
    );

    nci_rd_len_track u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (frm_clr),
        .stb     (byte_stb),
        .rx_byte (eng_rx_byte),
        .idx     (byte_idx),
        .first   (byte_first),
        .last    (byte_last)
    );

    nci_rd_hdr_check u_hdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (frm_clr),
        .stb     (byte_stb),
        .idx     (byte_idx),
        .rx_byte (eng_rx_byte),
        .exp_oid (exp_oid),
        .bad     (hdr_bad)
    );

    nci_rd_seq #(.TGT_ADDR(TGT_ADDR)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_in),
        .eng_done    (eng_done),
        .eng_rx_byte (eng_rx_byte),
        .tmo_hit     (tmo_hit),
        .win_hit     (win_hit),
        .byte_first  (byte_first),
        .byte_last   (byte_last),
        .hdr_bad     (hdr_bad),
        .tmr_clr     (tmr_clr),
        .tmr_en      (tmr_en),
        .win_clr     (win_clr),
        .win_en      (win_en),
        .frm_clr     (frm_clr),
        .byte_stb    (byte_stb),
        .regs        (regs)
    );

    assign cmd_valid     = regs.cmd_valid;
    assign cmd_op        = regs.op;
    assign cmd_byte      = regs.cmd_byte;
    assign cmd_nack      = regs.nack;
    assign out_valid     = regs.out_valid;
    assign out_data      = regs.out_data;
    assign out_sof       = regs.sof;
    assign out_eof       = regs.eof;
    assign err_mismatch  = regs.mism;
    assign err_underread = regs.err_under;
    assign err_timeout   = regs.err_tmo;

endmodule

// File: rtl/nci_rd_checker.sv
module nci_rd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_in,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       cmd_nack,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_eof,
    input logic       err_mismatch,
    input logic       err_underread,
    input logic       err_timeout
);

    assert_start_needs_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0) |-> $past(irq_in));

    assert_flags_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof) |-> out_valid);

    assert_valid_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_eof_nacked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> (cmd_valid && cmd_op == 2'd2 && cmd_nack));

    assert_underread_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_underread |=> err_underread);

    assert_mismatch_at_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_mismatch |-> out_eof);

    assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> err_timeout);

endmodule

bind nci_rsp_reader nci_rd_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_in        (irq_in),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_nack      (cmd_nack),
    .out_valid     (out_valid),
    .out_sof       (out_sof),
    .out_eof       (out_eof),
    .err_mismatch  (err_mismatch),
    .err_underread (err_underread),
    .err_timeout   (err_timeout)
);

// File: tb/sim_nci_rsp_reader.sv
module sim_nci_rsp_reader;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CLR_WAIT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_in = 1'b0;
    logic [7:0]  exp_oid = 8'h00;
    logic [15:0] tmo_limit = 16'd1000;
    logic        cmd_valid, cmd_nack, eng_done;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_byte, eng_rx_byte, out_data;
    logic        out_valid, out_sof, out_eof;
    logic        err_mismatch, err_underread, err_timeout;

    nci_rsp_reader #(.CLR_WAIT(CLR_WAIT)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .exp_oid(exp_oid),
        .tmo_limit(tmo_limit), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .cmd_nack(cmd_nack), .eng_done(eng_done),
        .eng_rx_byte(eng_rx_byte), .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .err_mismatch(err_mismatch),
        .err_underread(err_underread), .err_timeout(err_timeout)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] frame [0:299];
    int flen = 0, rd_ptr = 0, dly = 1;
    bit hang_rd = 0, stuck = 0;
    logic [7:0] got [0:299];
    bit got_sof [0:299];
    bit got_eof [0:299];
    bit nack_log [0:299];
    int got_n = 0, ak_n = 0, rd_cmds = 0, stop_n = 0, start_n = 0;
    bit mism_seen = 0;
    logic [7:0] last_addr = 8'h00;
    int cyc = 0, cyc_read = 0, cyc_tmo = 0, cyc_stop_done = 0, cyc_under = 0;
    bit pend = 0;
    int pend_cnt = 0;
    logic [1:0] pend_op = 2'd0;
    bit prev_tmo = 0, prev_under = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Byte-engine and target model plus output monitor, all at the falling edge.
    initial begin
        eng_done    = 1'b0;
        eng_rx_byte = 8'h00;
        forever begin
            @(negedge clk);
            cyc++;
            eng_done = 1'b0;
            if (pend) begin
                if (pend_cnt == 0) begin
                    pend = 0;
                    eng_done = 1'b1;
                    if (pend_op == 2'd1) begin
                        eng_rx_byte = frame[rd_ptr];
                        rd_ptr++;
                    end
                    if (pend_op == 2'd3) begin
                        cyc_stop_done = cyc;
                        if (rd_ptr == flen && !stuck) irq_in = 1'b0;
                    end
                end else begin
                    pend_cnt--;
                end
            end
            if (cmd_valid) begin
                case (cmd_op)
                    2'd0: begin start_n++; last_addr = cmd_byte; rd_ptr = 0; end
                    2'd1: begin rd_cmds++; cyc_read = cyc; end
                    2'd2: begin nack_log[ak_n] = cmd_nack; ak_n++; end
                    default: stop_n++;
                endcase
                if (!(hang_rd && cmd_op == 2'd1)) begin
                    pend = 1;
                    pend_cnt = dly - 1;
                    pend_op = cmd_op;
                end
            end
            if (out_valid) begin
                got[got_n] = out_data;
                got_sof[got_n] = out_sof;
                got_eof[got_n] = out_eof;
                got_n++;
            end
            if (err_mismatch) mism_seen = 1;
            if (err_timeout && !prev_tmo) begin
                cyc_tmo = cyc;
                irq_in = 1'b0;
            end
            if (err_underread && !prev_under) cyc_under = cyc;
            prev_tmo = err_timeout;
            prev_under = err_underread;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    task automatic do_reset;
        rst_n = 1'b0;
        irq_in = 1'b0;
        hang_rd = 0;
        stuck = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic build(input logic [7:0] mt, input logic [7:0] oid, input int n);
        frame[0] = mt;
        frame[1] = oid;
        frame[2] = n[7:0];
        for (int i = 0; i < n; i++) frame[3 + i] = 8'((i * 37 + n + 5) & 255);
        flen = n + 3;
        got_n = 0; ak_n = 0; rd_cmds = 0; mism_seen = 0;
    endtask

    task automatic run_frame(input logic [7:0] mt, input logic [7:0] oid,
                             input logic [7:0] eo, input int n, input int d);
        int stops0, bad, sofs, eofs, nacks;
        build(mt, oid, n);
        dly = d;
        exp_oid = eo;
        stops0 = stop_n;
        @(negedge clk);
        irq_in = 1'b1;
        for (int k = 0; k < 20000 && irq_in; k++) @(negedge clk);
        repeat (6) @(negedge clk);
        check(last_addr == 8'h51, "R1 address byte", last_addr, 8'h51);
        check(rd_cmds == n + 3, "R2 read commands", rd_cmds, n + 3);
        check(got_n == n + 3, "R3 byte count", got_n, n + 3);
        bad = 0; sofs = 0; eofs = 0;
        for (int i = 0; i < got_n; i++) begin
            if (got[i] != frame[i]) bad++;
            if (got_sof[i] != (i == 0)) sofs++;
            if (got_eof[i] != (i == n + 2)) eofs++;
        end
        check(bad == 0, "R3 byte values", bad, 0);
        check(sofs == 0 && eofs == 0, "R3 sof/eof placement", sofs + eofs, 0);
        nacks = 0;
        for (int i = 0; i < ak_n; i++) if (nack_log[i] != (i == n + 2)) nacks++;
        check(ak_n == n + 3 && nacks == 0, "R4 ack/nack choice", nacks, 0);
        check(stop_n == stops0 + 1, "R5 single stop", stop_n - stops0, 1);
        check(err_underread == 1'b0 && !cmd_valid, "R5 idle after irq clear", err_underread, 0);
        check(mism_seen == ((mt != 8'h40) || (oid != eo)), "R7 mismatch flag",
              mism_seen, ((mt != 8'h40) || (oid != eo)));
    endtask

    initial begin
        do_reset();
        // R9 reset state
        check(!cmd_valid && !out_valid && !out_sof && !out_eof, "R9 outputs idle",
              cmd_valid + out_valid + out_sof + out_eof, 0);
        check(!err_mismatch && !err_underread && !err_timeout, "R9 errors clear",
              err_mismatch + err_underread + err_timeout, 0);
        // R1 no read while the interrupt is low
        repeat (30) @(negedge clk);
        check(start_n == 0, "R1 no start without irq", start_n, 0);

        for (int n = 0; n < 10; n++) begin
            for (int d = 1; d <= 3; d++) begin
                logic [7:0] mt, oid, eo;
                mt  = (n % 4 == 3) ? 8'h60 : 8'h40;
                oid = 8'(n);
                eo  = (d == 2 && n % 3 == 0) ? 8'(n ^ 1) : 8'(n);
                run_frame(mt, oid, eo, n, d);
            end
        end
        run_frame(8'h40, 8'h00, 8'h00, 31, 2);
        run_frame(8'h40, 8'h07, 8'h07, 255, 1);

        // R6 underread: the target keeps its interrupt high after the frame
        begin
            int starts0;
            build(8'h40, 8'h00, 2);
            exp_oid = 8'h00;
            dly = 1;
            stuck = 1;
            @(negedge clk);
            irq_in = 1'b1;
            for (int k = 0; k < 5000 && !err_underread; k++) @(negedge clk);
            starts0 = start_n;
            stuck = 0;
            check(err_underread == 1'b1, "R6 underread flag", err_underread, 1);
            check(cyc_under - cyc_stop_done == CLR_WAIT + 2, "R6 window length",
                  cyc_under - cyc_stop_done, CLR_WAIT + 2);
            for (int k = 0; k < 5000 && irq_in; k++) @(negedge clk);
            repeat (6) @(negedge clk);
            check(start_n == starts0 + 1, "R6 new read starts", start_n - starts0, 1);
            check(err_underread == 1'b1, "R6 flag sticky", err_underread, 1);
        end

        // R8 timeout at several limits
        for (int t = 0; t < 3; t++) begin
            int lim, stops0, starts0;
            lim = 3 + t * 4;
            do_reset();
            tmo_limit = 16'(lim);
            build(8'h40, 8'h00, 1);
            dly = 1;
            hang_rd = 1;
            stops0 = stop_n;
            @(negedge clk);
            irq_in = 1'b1;
            for (int k = 0; k < 2000 && !err_timeout; k++) @(negedge clk);
            check(err_timeout == 1'b1, "R8 timeout flag", err_timeout, 1);
            check(cyc_tmo - cyc_read == lim + 1, "R8 timeout cycle", cyc_tmo - cyc_read, lim + 1);
            check(stop_n == stops0 + 1, "R8 abort stop", stop_n - stops0, 1);
            starts0 = start_n;
            repeat (30) @(negedge clk);
            check(start_n == starts0 && err_timeout, "R8 idle and sticky", start_n - starts0, 0);
            hang_rd = 0;
        end
        tmo_limit = 16'd1000;

        summary();
    end

endmodule